// File: doc/BRIEF.md
# Cascadable Eight-Request Priority Encoder

This block takes eight request lines and reports which one wins. All inputs and outputs are active low. Request 7 outranks every other request and request 0 ranks last. The block has no clock and no state. A single enable input gates the whole unit. When the unit is disabled, every output is held deasserted whatever the requests are.

Two separate status outputs make the unit chainable:

- **Group-valid** goes low when the unit is enabled and holds at least one request.
- **Chain-out** goes low when the unit is enabled and holds no request.

To build a wider encoder, connect the chain-out of a higher-ranked unit to the enable input of the next lower-ranked unit. The group-valid outputs of the units then supply the upper bits of the wider index.

Top module: `cascade_prio_enc`

## Requirements
- R1: The request lines `req_n[7:0]` are active low. When several are low at once, the one with the largest index wins, so index 7 has top priority and index 0 has the least.
- R2: The index output `idx_n[2:0]` carries the bitwise complement of the winning index. For example, a win by request 5 gives 3'b010 and a win by request 0 gives 3'b111.
- R3: `grp_n` is low exactly when `en_in_n` is low and at least one request line is low.
- R4: `chain_n` is low exactly when `en_in_n` is low and all eight request lines are high.
- R5: While `en_in_n` is high, `idx_n` reads 3'b111 and both `grp_n` and `chain_n` read high, for every request pattern.
- R6: While the unit is enabled with no request, `idx_n` reads 3'b111 and `grp_n` stays high. This separates the idle case from a real win by request 0, where `idx_n` also reads 3'b111 but `grp_n` is low.
- R7: `grp_n` and `chain_n` are never low at the same time.
- R8: The outputs are a pure function of the present inputs. They settle after an input change without any clock edge, and the same inputs always give the same outputs, whatever came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 8 | Request lines, active low; the larger index wins |
| en_in_n | input | 1 | Unit enable, active low |
| idx_n | output | 3 | Complemented index of the winning request |
| grp_n | output | 1 | Low when enabled and some request is present |
| chain_n | output | 1 | Low when enabled and no request is present; drives the next unit's enable |

## Verification
The assertions assume that the inputs are settled two-state values whenever the combinational processes evaluate, so they do not guard against X or Z on the request or enable pins. The stimulus only applies full 0/1 values. It changes all nine inputs together in one step and waits before sampling, so no check sees a half-updated pattern. The exhaustive sweep covers all 512 input combinations, including every enabled and disabled pattern, with no undefined levels.

// File: rtl/pe_pkg.sv
package pe_pkg;
  // Number of request lines per unit and width of the encoded index
  localparam int unsigned PE_NREQ  = 8;
  localparam int unsigned PE_IDX_W = $clog2(PE_NREQ);
endpackage

// File: rtl/pe_top_term.sv
// Finds the highest asserted request and marks it with a one-hot term.
module pe_top_term #(
  parameter int unsigned N = pe_pkg::PE_NREQ
) (
  input  logic [N-1:0] act,
  output logic [N-1:0] hot,
  output logic         found
);
  // above[i] is high when any request at index i or higher is active
  logic [N:0] above;
  assign above[N] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_term
    assign above[i] = above[i+1] | act[i];
    assign hot[i]   = act[i] & ~above[i+1];
  end

  assign found = above[0];

  always_comb begin
    assert_onehot_R1: assert ($onehot0(hot))
      else $error("more than one winning term");
    assert_found_R1: assert (found == (hot != '0))
      else $error("found flag disagrees with terms");
  end
endmodule

// File: rtl/pe_bin_or.sv
// Turns the one-hot winner into a binary index by OR-ing the terms per bit.
module pe_bin_or #(
  parameter int unsigned N = pe_pkg::PE_NREQ,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] hot,
  output logic [W-1:0] bin
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      bin[b] = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (((i >> b) & 1) == 1) bin[b] = bin[b] | hot[i];
      end
    end
  end

  always_comb begin
    if (hot != '0) begin
      assert_index_R2: assert (hot[bin] == 1'b1)
        else $error("index does not point at the winning term");
    end
  end
endmodule

// File: rtl/cascade_prio_enc.sv
module cascade_prio_enc (
  input  logic [7:0] req_n,
  input  logic       en_in_n,
  output logic [2:0] idx_n,
  output logic       grp_n,
  output logic       chain_n
);
  localparam int unsigned N = pe_pkg::PE_NREQ;
  localparam int unsigned W = pe_pkg::PE_IDX_W;

  logic [N-1:0] act;
  logic [N-1:0] hot;
  logic         found;
  logic [W-1:0] bin;
  logic         en;

  assign act = ~req_n;
  assign en  = ~en_in_n;

  pe_top_term #(.N(N)) u_term (
    .act   (act),
    .hot   (hot),
    .found (found)
  );

  pe_bin_or #(.N(N)) u_bin (
    .hot (hot),
    .bin (bin)
  );

  // Output gating: a disabled unit holds every output high
  always_comb begin
    idx_n   = en ? ~bin : '1;
    grp_n   = ~(en & found);
    chain_n = ~(en & ~found);
  end

  always_comb begin
    if (en_in_n) begin
      assert_off_R5: assert (idx_n == 3'b111 && grp_n && chain_n)
        else $error("disabled unit drives an asserted output");
    end
    assert_excl_R7: assert (!(!grp_n && !chain_n))
      else $error("group-valid and chain-out both low");
    assert_grp_R3: assert (grp_n == !(!en_in_n && req_n != 8'hFF))
      else $error("group-valid wrong");
    assert_chain_R4: assert (chain_n == !(!en_in_n && req_n == 8'hFF))
      else $error("chain-out wrong");
    if (!grp_n) begin
      assert_prio_R1: assert (((~req_n) >> (~idx_n)) == 8'd1)
        else $error("reported request is not the highest one");
    end
    if (!chain_n) begin
      assert_idle_R6: assert (idx_n == 3'b111)
        else $error("idle index not all ones");
    end
  end
endmodule

// File: tb/sim_cascade_prio_enc.sv
module sim_cascade_prio_enc;
  logic       clk = 1'b0;
  logic [7:0] req_n;
  logic       en_in_n;
  logic [2:0] idx_n;
  logic       grp_n;
  logic       chain_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  cascade_prio_enc u0 (
    .req_n   (req_n),
    .en_in_n (en_in_n),
    .idx_n   (idx_n),
    .grp_n   (grp_n),
    .chain_n (chain_n)
  );

  // Directed vectors: {en_in_n, req_n[7:0], idx_n[2:0], grp_n, chain_n}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    14'b1_00000000_111_1_1,  // R5 disabled, all requests low
    14'b1_11111111_111_1_1,  // R5 disabled, idle
    14'b0_11111111_111_1_0,  // R4 R6 enabled, idle
    14'b0_11111110_111_0_1,  // R6 request 0 only
    14'b0_01111111_000_0_1,  // R2 request 7 only
    14'b0_00000000_000_0_1,  // R1 all requests
    14'b0_11011111_010_0_1,  // R2 request 5
    14'b0_11110101_100_0_1,  // R1 requests 3 and 1
    14'b0_11111101_110_0_1,  // R2 request 1
    14'b0_10111111_001_0_1,  // R2 request 6
    14'b0_11101111_011_0_1,  // R2 request 4
    14'b0_11111011_101_0_1,  // R2 request 2
    14'b0_11110111_100_0_1,  // R2 request 3
    14'b1_01011010_111_1_1   // R5 disabled, mixed
  };

  task automatic check(input string req, input logic [2:0] act_v,
                       input logic [2:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (en_in_n=%b req_n=%b)",
               req, act_v, exp_v, en_in_n, req_n);
    end
  endtask

  // Independent model built from the requirements
  function automatic logic [4:0] model(input logic en_n_v, input logic [7:0] r);
    logic [2:0] ix = 3'b111;
    logic any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!r[i]) begin
        any = 1'b1;
        ix  = ~3'(i);
      end
    end
    if (en_n_v) return 5'b111_1_1;
    if (!any)   return 5'b111_1_0;
    return {ix, 1'b0, 1'b1};
  endfunction

  task automatic apply(input logic e, input logic [7:0] r);
    @(negedge clk);
    en_in_n = e;
    req_n   = r;
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [4:0] exp;
    // Idle state: unit disabled with no requests (R5)
    en_in_n = 1'b1;
    req_n   = 8'hFF;
    #2;
    check("R5 idle idx", idx_n, 3'b111);
    check("R5 idle status", {1'b0, grp_n, chain_n}, 3'b011);

    // Directed table
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][13], VEC[v][12:5]);
      check("R2 table idx", idx_n, VEC[v][4:2]);
      check("R3 table grp", {2'b00, grp_n}, {2'b00, VEC[v][1]});
      check("R4 table chain", {2'b00, chain_n}, {2'b00, VEC[v][0]});
    end

    // Exhaustive sweep over all 512 combinations (R1..R7)
    for (int k = 0; k < 512; k++) begin
      apply(k[8], k[7:0]);
      exp = model(k[8], k[7:0]);
      check("R1 R2 sweep idx", idx_n, exp[4:2]);
      check("R3 sweep grp", {2'b00, grp_n}, {2'b00, exp[1]});
      check("R4 sweep chain", {2'b00, chain_n}, {2'b00, exp[0]});
      check("R7 sweep exclusive", {2'b00, (!grp_n && !chain_n)}, 3'b000);
    end

    // R8: change inputs between clock edges, outputs follow with no edge
    @(posedge clk);
    #2;
    en_in_n = 1'b0;
    req_n   = 8'b1110_1111;
    #1;
    check("R8 no-edge idx", idx_n, 3'b011);
    req_n = 8'b1111_1111;
    #1;
    check("R8 no-edge chain", {2'b00, chain_n}, 3'b000);
    // R8: same inputs after a different history give the same result
    apply(1'b0, 8'h00);
    apply(1'b0, 8'b1101_1111);
    check("R8 history idx", idx_n, 3'b010);
    apply(1'b1, 8'h00);
    apply(1'b0, 8'b1101_1111);
    check("R8 history idx again", idx_n, 3'b010);
    // R6: request 0 versus idle differ only in grp_n
    apply(1'b0, 8'hFE);
    check("R6 req0 grp", {2'b00, grp_n}, 3'b000);
    apply(1'b0, 8'hFF);
    check("R6 idle grp", {2'b00, grp_n}, 3'b001);

    done = 1;
    finish_run();
  end
endmodule